// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block holds the running state of a single DMA channel and steps it through a run of bus transfers. Each transfer has two halves. First a read request goes out at the read pointer. The returned data is kept in a holding register. Then a write request carries that data to the write pointer. After a clean write the channel advances its pointers by the transfer size, if the matching increment bits allow it, and decrements its remaining-transfer count. When the count runs out, the channel drops its busy status and raises its interrupt flag.

Software programs the channel through one control write strobe. The same strobe carries the enable bit, the two increment bits, the size code and three write-one-to-clear bits. Pointers and count are loaded through separate load strobes. A trigger pulse starts the run. The bus side is a level request with address, size and direction. The request is held until a same-cycle acknowledge, which comes with an error bit and read data. Only one request is in flight at a time.

Clearing enable pauses the run without dropping busy. A bus error on either half stops the channel, sets the matching sticky error flag and always sets the interrupt flag.

Top module: `dmaseq_top`

## Requirements
- R1: After reset, busy, rdErr, wrErr, anyErr, irq and busReq are 0. rdAddr, wrAddr and count are 0, and all control fields are 0.
- R2: A trigger pulse sets busy at the next clock edge when all of these hold: enable is 1, busy is 0, count is nonzero and neither error flag is set. Once busy, the channel requests whenever enable is 1.
- R3: Each transfer is a read request followed by a write request. A read request has busWrite=0 and busAddr=rdAddr. A write request has busWrite=1, busAddr=wrAddr, and busWdata equal to the data returned by the preceding read. A request is held until a cycle in which busReq and busAck are both 1, and only one is in flight.
- R4: After each error-free write completion, rdAddr advances by the step when the read-increment bit is 1 and is unchanged otherwise. wrAddr does the same under the write-increment bit. A load strobe in the same cycle takes precedence.
- R5: The size code sits at control bits [4:3]. Codes 0, 1, 2 and 3 give steps of 1, 2, 4 and 4 bytes, and busSize shows 0, 1, 2 and 2 respectively.
- R6: count decrements by one on each error-free write completion. The completion that takes it from 1 to 0 clears busy and sets irq.
- R7: While busy, writing enable (control bit 0) to 0 holds busReq at 0 and keeps busy at 1, with pointers and count unchanged. Writing it back to 1 resumes the run where it stopped.
- R8: An error on a read completion sets rdErr, and an error on a write completion sets wrErr. Either one clears busy and sets irq, with pointers and count left unchanged.
- R9: anyErr equals rdErr OR wrErr.
- R10: A control write clears irq, rdErr and wrErr for each of bits 5, 6 and 7 (respectively) written as 1. Bits written as 0 leave the flags unchanged. A flag set in the same cycle as its clear stays set.
- R11: A trigger is ignored while enable is 0, while busy, while count is 0, or while either error flag is set.
- R12: The control bits at positions 1 and 2 are the read-increment and write-increment bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | Control write strobe |
| ctrlWdata | input | 8 | Control data: [0] enable, [1] read increment, [2] write increment, [4:3] size, [5] irq clear, [6] read-error clear, [7] write-error clear |
| trigger | input | 1 | Start pulse |
| ldRdAddr | input | 1 | Load rdAddr from ldValue |
| ldWrAddr | input | 1 | Load wrAddr from ldValue |
| ldCount | input | 1 | Load count from the low bits of ldValue |
| ldValue | input | ADDR_W | Load value |
| busReq | output | 1 | Bus request valid |
| busWrite | output | 1 | 1 = write half, 0 = read half |
| busAddr | output | ADDR_W | Request address |
| busSize | output | 2 | Effective size code |
| busWdata | output | DATA_W | Write data |
| busAck | input | 1 | Completion of the current request |
| busErr | input | 1 | Error on the completion |
| busRdata | input | DATA_W | Read data on completion |
| busy | output | 1 | Channel running or paused |
| rdErr | output | 1 | Sticky read-error flag |
| wrErr | output | 1 | Sticky write-error flag |
| anyErr | output | 1 | OR of the error flags |
| irq | output | 1 | Sticky interrupt flag |
| rdAddr | output | ADDR_W | Read pointer |
| wrAddr | output | ADDR_W | Write pointer |
| count | output | CNT_W | Transfers remaining |

## Verification
An error can land on a bus completion in exactly the cycle that software writes ones to the clear bits. Likewise, the run-ending completion can coincide with an interrupt clear. To provoke the collision, the bench's bus responder raises a control write with all three clear bits in the very cycle it returns an error acknowledge. The cycle-accurate reference model predicts that the flags stay set, and the bench confirms it both through the per-clock comparison and through a directed check of the write-error flag and irq afterwards.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  localparam int CTL_W       = 8;
  localparam int BIT_EN      = 0;
  localparam int BIT_INC_RD  = 1;
  localparam int BIT_INC_WR  = 2;
  localparam int BIT_SZ_LO   = 3;
  localparam int BIT_SZ_HI   = 4;
  localparam int BIT_IRQ_CLR = 5;
  localparam int BIT_RDE_CLR = 6;
  localparam int BIT_WRE_CLR = 7;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xferSize_t;

  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // clean read completion: latch read data
    logic advance;   // clean write completion: move pointers, count down
  } dpStrobe_t;

  function automatic logic [2:0] stepBytes(xferSize_t s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic xferSize_t effSize(xferSize_t s);
    return (s == SZ_RSVD) ? SZ_WORD : s;
  endfunction

endpackage

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWr,
  input  logic [CTL_W-1:0]     ctrlWdata,
  input  logic                 trigger,
  input  logic                 busAck,
  input  logic                 busErr,
  input  logic                 countIsOne,
  input  logic                 countIsZero,
  output logic                 enable,
  output logic                 incRd,
  output logic                 incWr,
  output xferSize_t            cfgSize,
  output logic                 busy,
  output phase_t               phase,
  output logic                 busReq,
  output logic                 rdErr,
  output logic                 wrErr,
  output logic                 irq,
  output dpStrobe_t            strobe
);

  logic reqLive, done, errHit, rdBad, wrBad, startOk, lastDone;

  assign reqLive = busy & enable;
  assign done    = reqLive & busAck;
  assign rdBad   = done & (phase == PH_READ)  & busErr;
  assign wrBad   = done & (phase == PH_WRITE) & busErr;
  assign errHit  = rdBad | wrBad;

  assign strobe.capture = done & (phase == PH_READ)  & ~busErr;
  assign strobe.advance = done & (phase == PH_WRITE) & ~busErr;

  assign lastDone = strobe.advance & countIsOne;
  assign startOk  = trigger & enable & ~busy & ~countIsZero & ~rdErr & ~wrErr;
  assign busReq   = reqLive;

  // configuration fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      incRd   <= 1'b0;
      incWr   <= 1'b0;
      cfgSize <= SZ_BYTE;
    end else if (ctrlWr) begin
      enable  <= ctrlWdata[BIT_EN];
      incRd   <= ctrlWdata[BIT_INC_RD];
      incWr   <= ctrlWdata[BIT_INC_WR];
      cfgSize <= xferSize_t'(ctrlWdata[BIT_SZ_HI:BIT_SZ_LO]);
    end
  end

  // run state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      phase <= PH_READ;
    end else begin
      if (startOk) begin
        busy  <= 1'b1;
        phase <= PH_READ;
      end else if (errHit) begin
        busy  <= 1'b0;
        phase <= PH_READ;
      end else if (strobe.capture) begin
        phase <= PH_WRITE;
      end else if (strobe.advance) begin
        phase <= PH_READ;
        if (countIsOne) busy <= 1'b0;
      end
    end
  end

  // sticky flags: set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdErr <= 1'b0;
      wrErr <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (rdBad)                                rdErr <= 1'b1;
      else if (ctrlWr && ctrlWdata[BIT_RDE_CLR]) rdErr <= 1'b0;
      if (wrBad)                                wrErr <= 1'b1;
      else if (ctrlWr && ctrlWdata[BIT_WRE_CLR]) wrErr <= 1'b0;
      if (errHit || lastDone)                    irq <= 1'b1;
      else if (ctrlWr && ctrlWdata[BIT_IRQ_CLR]) irq <= 1'b0;
    end
  end

  AST_REQ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busy); // R3
  AST_PAUSE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !enable) |=> busy); // R7
  AST_ERROR_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && busErr) |=> (!busy && irq)); // R8
  AST_TRIGGER_IGNORED_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && trigger && !enable) |=> !busy); // R11
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capture && strobe.advance)); // R3

endmodule

// File: rtl/dmaseq_dpath.sv
module dmaseq_dpath
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              incRd,
  input  logic              incWr,
  input  xferSize_t         cfgSize,
  input  phase_t            phase,
  input  logic              ldRdAddr,
  input  logic              ldWrAddr,
  input  logic              ldCount,
  input  logic [ADDR_W-1:0] ldValue,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] holdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              countIsOne,
  output logic              countIsZero
);

  localparam int NPTR = 2;        // index 0 = read pointer, 1 = write pointer
  localparam int PAD  = ADDR_W - 3;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] ptrQ  [NPTR];
  logic [NPTR-1:0]   incSel;
  logic [NPTR-1:0]   ldSel;

  assign step   = {{PAD{1'b0}}, stepBytes(cfgSize)};
  assign incSel = {incWr, incRd};
  assign ldSel  = {ldWrAddr, ldRdAddr};

  for (genvar i = 0; i < NPTR; i++) begin : gPtr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          ptrQ[i] <= '0;
      else if (ldSel[i])                  ptrQ[i] <= ldValue;
      else if (strobe.advance && incSel[i]) ptrQ[i] <= ptrQ[i] + step;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (ldCount)        count <= ldValue[CNT_W-1:0];
    else if (strobe.advance) count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdData <= '0;
    else if (strobe.capture) holdData <= busRdata;
  end

  assign rdAddr      = ptrQ[0];
  assign wrAddr      = ptrQ[1];
  assign busAddr     = (phase == PH_WRITE) ? ptrQ[1] : ptrQ[0];
  assign countIsOne  = (count == CNT_W'(1));
  assign countIsZero = (count == '0);

  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !ldCount) |=> (count == $past(count) - 1'b1)); // R6
  AST_RDPTR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !incRd && !ldRdAddr) |=> $stable(rdAddr)); // R4
  AST_WRPTR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !ldWrAddr) |=> $stable(wrAddr)); // R4

endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [7:0]        ctrlWdata,
  input  logic              trigger,
  input  logic              ldRdAddr,
  input  logic              ldWrAddr,
  input  logic              ldCount,
  input  logic [ADDR_W-1:0] ldValue,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic              busErr,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busy,
  output logic              rdErr,
  output logic              wrErr,
  output logic              anyErr,
  output logic              irq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [CNT_W-1:0]  count
);

  dpStrobe_t strobe;
  phase_t    phase;
  xferSize_t cfgSize;
  logic      enable, incRd, incWr, countIsOne, countIsZero;

  dmaseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata),
    .trigger(trigger), .busAck(busAck), .busErr(busErr),
    .countIsOne(countIsOne), .countIsZero(countIsZero),
    .enable(enable), .incRd(incRd), .incWr(incWr), .cfgSize(cfgSize),
    .busy(busy), .phase(phase), .busReq(busReq),
    .rdErr(rdErr), .wrErr(wrErr), .irq(irq), .strobe(strobe)
  );

  dmaseq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .incRd(incRd), .incWr(incWr),
    .cfgSize(cfgSize), .phase(phase), .ldRdAddr(ldRdAddr), .ldWrAddr(ldWrAddr),
    .ldCount(ldCount), .ldValue(ldValue), .busRdata(busRdata),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .count(count), .holdData(busWdata),
    .busAddr(busAddr), .countIsOne(countIsOne), .countIsZero(countIsZero)
  );

  assign busWrite = (phase == PH_WRITE);
  assign busSize  = effSize(cfgSize);
  assign anyErr   = rdErr | wrErr;

  AST_ANYERR_IS_OR: assert property (@(posedge clk) disable iff (!rstN)
    (rdErr || wrErr) |-> anyErr); // R9

endmodule

// File: tb/tb_dmaseq_top.sv
module tb_dmaseq_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        ctrlWrT = 0, clrPulse = 0, trigger = 0;
  logic [7:0]  ctrlWdataT = 0, clrData = 0;
  logic        ldRdAddr = 0, ldWrAddr = 0, ldCount = 0;
  logic [31:0] ldValue = 0;
  logic        busAck = 0, busErr = 0;
  logic [31:0] busRdata = 0;
  logic        ctrlWr;
  logic [7:0]  ctrlWdata;
  logic        busReq, busWrite, busy, rdErr, wrErr, anyErr, irq;
  logic [31:0] busAddr, busWdata, rdAddr, wrAddr;
  logic [1:0]  busSize;
  logic [15:0] count;

  assign ctrlWr    = ctrlWrT | clrPulse;
  assign ctrlWdata = clrPulse ? clrData : ctrlWdataT;

  dmaseq_top dut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata), .trigger(trigger),
    .ldRdAddr(ldRdAddr), .ldWrAddr(ldWrAddr), .ldCount(ldCount), .ldValue(ldValue),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busAck(busAck), .busErr(busErr), .busRdata(busRdata),
    .busy(busy), .rdErr(rdErr), .wrErr(wrErr), .anyErr(anyErr), .irq(irq),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .count(count)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  bit        mBusy, mPh, mEn, mIncR, mIncW, mRdErr, mWrErr, mIrq;
  bit [1:0]  mSize;
  bit [31:0] mRd, mWr, mHold;
  bit [15:0] mCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mPh = 0; mEn = 0; mIncR = 0; mIncW = 0; mRdErr = 0; mWrErr = 0;
      mIrq = 0; mSize = 0; mRd = 0; mWr = 0; mHold = 0; mCnt = 0;
    end else begin
      bit done, rdOk, wrOk, rdBad, wrBad, start, last;
      int st;
      done  = mBusy && mEn && busAck;
      rdOk  = done && !mPh && !busErr;
      wrOk  = done &&  mPh && !busErr;
      rdBad = done && !mPh &&  busErr;
      wrBad = done &&  mPh &&  busErr;
      last  = wrOk && (mCnt == 1);
      st    = (mSize == 0) ? 1 : (mSize == 1) ? 2 : 4;
      start = trigger && mEn && !mBusy && (mCnt != 0) && !mRdErr && !mWrErr;
      if (rdOk) mHold = busRdata;
      if (ldRdAddr) mRd = ldValue; else if (wrOk && mIncR) mRd = mRd + st;
      if (ldWrAddr) mWr = ldValue; else if (wrOk && mIncW) mWr = mWr + st;
      if (ldCount) mCnt = ldValue[15:0]; else if (wrOk) mCnt = mCnt - 1;
      if (start) begin mBusy = 1; mPh = 0; end
      else if (rdBad || wrBad) begin mBusy = 0; mPh = 0; end
      else if (rdOk) mPh = 1;
      else if (wrOk) begin mPh = 0; if (last) mBusy = 0; end
      if (rdBad) mRdErr = 1; else if (ctrlWr && ctrlWdata[6]) mRdErr = 0;
      if (wrBad) mWrErr = 1; else if (ctrlWr && ctrlWdata[7]) mWrErr = 0;
      if (rdBad || wrBad || last) mIrq = 1; else if (ctrlWr && ctrlWdata[5]) mIrq = 0;
      if (ctrlWr) begin
        mEn = ctrlWdata[0]; mIncR = ctrlWdata[1]; mIncW = ctrlWdata[2]; mSize = ctrlWdata[4:3];
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit req;
      req = mBusy && mEn;
      chk("R2 busy", busy, mBusy);
      chk("R7 busReq", busReq, req);
      if (req) begin
        chk("R3 busWrite", busWrite, mPh);
        chk("R3 busAddr", busAddr, mPh ? mWr : mRd);
        chk("R5 busSize", busSize, (mSize == 3) ? 2 : mSize);
        if (mPh) chk("R3 busWdata", busWdata, mHold);
      end
      chk("R4 rdAddr", rdAddr, mRd);
      chk("R4 wrAddr", wrAddr, mWr);
      chk("R6 count", count, mCnt);
      chk("R8 rdErr", rdErr, mRdErr);
      chk("R8 wrErr", wrErr, mWrErr);
      chk("R9 anyErr", anyErr, mRdErr | mWrErr);
      chk("R10 irq", irq, mIrq);
    end
  end

  // ---------------- bus responder ----------------
  int  lat = 0, waitCnt = 0;
  bit  errArm = 0, errOnWrite = 0, clrSame = 0;
  bit [31:0] errAddr = 0;
  logic [7:0] cfgNow = 0;

  always @(negedge clk) begin
    #1;
    busAck = 0; busErr = 0; clrPulse = 0;
    if (busReq) begin
      if (waitCnt >= lat) begin
        waitCnt = 0;
        busAck = 1;
        busRdata = busAddr ^ 32'hC3A5_0000 ^ (busAddr << 7);
        if (errArm && (busWrite == errOnWrite) && (busAddr == errAddr)) begin
          busErr = 1; errArm = 0;
          if (clrSame) begin clrPulse = 1; clrData = cfgNow | 8'hE0; end
        end
      end else waitCnt++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic cfgWrite(input logic [7:0] d);
    @(negedge clk); #2; ctrlWrT = 1; ctrlWdataT = d;
    if (d[0]) cfgNow = d & 8'h1F; else cfgNow = d & 8'h1F;
    @(negedge clk); #2; ctrlWrT = 0;
  endtask

  task automatic loadAll(input logic [31:0] ra, input logic [31:0] wa, input logic [15:0] n);
    @(negedge clk); #2; ldRdAddr = 1; ldValue = ra;
    @(negedge clk); #2; ldRdAddr = 0; ldWrAddr = 1; ldValue = wa;
    @(negedge clk); #2; ldWrAddr = 0; ldCount = 1; ldValue = {16'h0, n};
    @(negedge clk); #2; ldCount = 0;
  endtask

  task automatic kick();
    @(negedge clk); #2; trigger = 1;
    @(negedge clk); #2; trigger = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    #3;
  endtask

  // ctrl byte: [0] en [1] incRd [2] incWr [4:3] size
  function automatic logic [7:0] cfg(input bit en, input bit ir, input bit iw, input logic [1:0] sz);
    return {3'b000, sz, iw, ir, en};
  endfunction

  localparam int WDOG = 150000;
  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rstN = 1;
    @(negedge clk); #3;
    // R1 reset state
    chk("R1 busy", busy, 0);       chk("R1 busReq", busReq, 0);
    chk("R1 irq", irq, 0);         chk("R1 anyErr", anyErr, 0);
    chk("R1 rdAddr", rdAddr, 0);   chk("R1 count", count, 0);

    // R11 trigger ignored with enable clear
    loadAll(32'h1000, 32'h2000, 16'd4);
    kick(); #3 chk("R11 trigger while disabled", busy, 0);
    // R11 trigger ignored with zero count
    cfgWrite(cfg(1, 1, 1, 2'd2));
    loadAll(32'h1000, 32'h2000, 16'd0);
    kick(); #3 chk("R11 trigger with zero count", busy, 0);

    // R2 R4 R6 word, both increments, zero latency
    loadAll(32'h1000, 32'h2000, 16'd4);
    kick(); #3 chk("R2 busy after trigger", busy, 1);
    waitIdle();
    chk("R4 rd advanced by words", rdAddr, 32'h1010);
    chk("R4 wr advanced by words", wrAddr, 32'h2010);
    chk("R6 irq at count zero", irq, 1);
    chk("R6 count zero", count, 0);
    cfgWrite(cfg(1, 1, 1, 2'd2));
    chk("R10 irq kept when clear bit 0", irq, 1);
    cfgWrite(cfg(1, 1, 1, 2'd2) | 8'h20);
    chk("R10 irq cleared", irq, 0);

    // R5 R12 byte, read increment only, latency 2
    lat = 2;
    cfgWrite(cfg(1, 1, 0, 2'd0) | 8'h20);
    loadAll(32'h3001, 32'h4000, 16'd3);
    kick(); waitIdle();
    chk("R5 byte step", rdAddr, 32'h3004);
    chk("R12 write pointer fixed", wrAddr, 32'h4000);
    // halfword, write increment only
    lat = 1;
    cfgWrite(cfg(1, 0, 1, 2'd1) | 8'h20);
    loadAll(32'h5000, 32'h6002, 16'd5);
    kick(); waitIdle();
    chk("R5 halfword step", wrAddr, 32'h600C);
    chk("R12 read pointer fixed", rdAddr, 32'h5000);
    // reserved size treated as word
    lat = 0;
    cfgWrite(cfg(1, 1, 1, 2'd3) | 8'h20);
    loadAll(32'h7000, 32'h8000, 16'd2);
    kick(); waitIdle();
    chk("R5 reserved code steps 4", rdAddr, 32'h7008);

    // R7 pause and resume
    lat = 1;
    cfgWrite(cfg(1, 1, 1, 2'd2) | 8'h20);
    loadAll(32'h9000, 32'hA000, 16'd6);
    kick();
    repeat (5) @(negedge clk);
    cfgWrite(cfg(0, 1, 1, 2'd2));
    repeat (8) @(negedge clk); #3;
    chk("R7 busy held while paused", busy, 1);
    chk("R7 no request while paused", busReq, 0);
    kick(); #3 chk("R11 trigger while busy keeps run", busy, 1);
    cfgWrite(cfg(1, 1, 1, 2'd2));
    waitIdle();
    chk("R7 resumed to completion", count, 0);
    chk("R7 final read pointer", rdAddr, 32'h9018);

    // R8 read error on third read
    lat = 0;
    cfgWrite(cfg(1, 1, 1, 2'd2) | 8'h20);
    loadAll(32'h0100, 32'h0800, 16'd5);
    errArm = 1; errOnWrite = 0; errAddr = 32'h0108; clrSame = 0;
    kick(); waitIdle();
    chk("R8 rdErr set", rdErr, 1);
    chk("R8 irq on error", irq, 1);
    chk("R8 count kept", count, 3);
    chk("R8 rd pointer kept", rdAddr, 32'h0108);
    chk("R9 anyErr", anyErr, 1);
    kick(); #3 chk("R11 trigger while error flagged", busy, 0);

    // R10 write error colliding with a clear in the same cycle
    cfgWrite(cfg(1, 1, 1, 2'd2) | 8'hE0);
    chk("R10 rdErr cleared", rdErr, 0);
    loadAll(32'h0200, 32'h0300, 16'd4);
    errArm = 1; errOnWrite = 1; errAddr = 32'h0304; clrSame = 1;
    kick(); waitIdle();
    chk("R10 set wins over clear wrErr", wrErr, 1);
    chk("R10 set wins over clear irq", irq, 1);
    chk("R8 count after write error", count, 3);
    chk("R9 anyErr from wrErr", anyErr, 1);
    cfgWrite(cfg(1, 1, 1, 2'd2) | 8'hE0);
    chk("R10 wrErr cleared", wrErr, 0);
    chk("R9 anyErr cleared", anyErr, 0);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule